// File: doc/BRIEF.md
# DRAM Cache Bank Access Sequencer

This block drives the bank-level timing of one DRAM cache hit at a time. An upstream presence filter has already decided that the requested block lives in the DRAM cache; the sequencer receives the bank, the row and the set slot inside that row, and walks the access through its fixed phases. The phases are: an optional row activation, a column read of the set's tag block, the tag block transfer on the bus, a wait for the tag comparison, a column read of the data block, and the data transfer.

The sequencer remembers which row is open in every bank. If the requested row is already open, activation is skipped. Otherwise the new row becomes the open one. The tag comparison is done outside the block and is returned on an input. On a mismatch the access stops after the comparison wait, with no data phase. Each finished access raises a one-cycle done pulse that carries the row-buffer and tag outcomes. A pair of per-bank counters, readable through a bank select input, records how many finished accesses found their row open and how many did not.

Top module: `dcache_bank_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0, `phase` is 0 (idle), and every bank's two counters read 0.
- R2: The first access to any bank after reset is a row-buffer miss (`done_row_hit` = 0). When its tags match, `done` rises 64 clock edges after the accepting edge.
- R3: An access to the row that is open in its bank is a row-buffer hit (`done_row_hit` = 1), spends no cycle in activation and, when its tags match, completes 46 edges after acceptance.
- R4: An access to a different row of a bank is a row-buffer miss, and that row becomes the open row of the bank. A later access to the previously open row is therefore also a miss.
- R5: Open rows are tracked per bank: opening a row in one bank does not change hit or miss results in another bank.
- R6: `phase` shows the step in progress, coded 1 = activation (18 cycles), 2 = tag column read (18), 3 = tag bus transfer (4), 4 = tag check (2), 5 = data column read (18), 6 = data bus transfer (4), 0 = idle. Throughout the access, `cur_bank`, `cur_row` and `cur_set` hold the accepted address.
- R7: If `tag_match` is 0 during the last cycle of the tag check, the access ends with `done_tag_hit` = 0 and no data phase. This takes 24 edges on a row-buffer hit and 42 edges on a row-buffer miss.
- R8: `req_ready` is 0 while an access is in progress. A request held valid during that time starts nothing and changes no counter.
- R9: `done` is a single-cycle pulse. `done_row_hit` and `done_tag_hit` are valid while it is high, and `done_tag_hit` is 1 on a completed data transfer.
- R10: Each finished access adds exactly one to the hit counter or to the miss counter of its own bank, chosen by its row-buffer outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken on this edge |
| req_bank | input | 5 | Bank index |
| req_row | input | 12 | Row number within the bank |
| req_set | input | 2 | Set slot within the row |
| tag_match | input | 1 | External tag comparison result, sampled in the last check cycle |
| phase | output | 3 | Current access step (code in R6) |
| cur_bank | output | 5 | Bank of the access in flight |
| cur_row | output | 12 | Row of the access in flight |
| cur_set | output | 2 | Set slot of the access in flight |
| done | output | 1 | One-cycle completion pulse |
| done_row_hit | output | 1 | Row was already open |
| done_tag_hit | output | 1 | Tags matched and data was transferred |
| stat_bank | input | 5 | Bank whose counters are shown |
| stat_row_hits | output | 16 | Row-buffer hit count of the selected bank |
| stat_row_misses | output | 16 | Row-buffer miss count of the selected bank |

## Verification
The hardest case to reach is an open row being replaced and then revisited. This is what R4 and R5 cover: a bank must see a hit, then a miss on another row, then a miss when the old row returns, while a second bank keeps its own open row untouched across all of it. The stimulus table orders accesses to bank 0 and bank 1 in exactly that interleaving, and it reaches the last bank and last row to cover the index edges. A directed run keeps a request from an untouched bank valid during a whole access, then reads that bank's counters to show that nothing was taken.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ACT  = 3'd1,
        PH_CTAG = 3'd2,
        PH_BTAG = 3'd3,
        PH_CHK  = 3'd4,
        PH_CDAT = 3'd5,
        PH_BDAT = 3'd6
    } phase_e;

endpackage

// File: rtl/dcs_open_rows.sv
module dcs_open_rows #(
    parameter int NUM_BANKS = 32,
    parameter int NUM_ROWS  = 4096,
    localparam int BW = $clog2(NUM_BANKS),
    localparam int RW = $clog2(NUM_ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] lk_bank,
    input  logic [RW-1:0] lk_row,
    output logic          lk_hit,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_bank,
    input  logic [RW-1:0] wr_row
);

    typedef struct packed {
        logic [NUM_BANKS-1:0]         vld;
        logic [NUM_BANKS-1:0][RW-1:0] row;
    } tbl_t;

    tbl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (wr_en && wr_bank == BW'(b)) begin
                st_d.vld[b] = 1'b1;
                st_d.row[b] = wr_row;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lk_hit = st_q.vld[lk_bank] && (st_q.row[lk_bank] == lk_row);

    // R4: a written row is the open row of its bank on the following cycle
    p_write_opens_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.vld[$past(wr_bank)] && st_q.row[$past(wr_bank)] == $past(wr_row)));

endmodule

// File: rtl/dcs_access_fsm.sv
module dcs_access_fsm
    import dcs_pkg::*;
#(
    parameter int BW          = 5,
    parameter int RW          = 12,
    parameter int SW          = 2,
    parameter int T_ACT       = 18,
    parameter int T_CAS       = 18,
    parameter int BLOCK_BEATS = 4,
    parameter int T_CHK       = 2,
    localparam int MAX_A  = (T_ACT > T_CAS) ? T_ACT : T_CAS,
    localparam int MAX_B  = (BLOCK_BEATS > T_CHK) ? BLOCK_BEATS : T_CHK,
    localparam int MAX_L  = (MAX_A > MAX_B) ? MAX_A : MAX_B,
    localparam int CNT_W  = $clog2(MAX_L + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [BW-1:0] req_bank,
    input  logic [RW-1:0] req_row,
    input  logic [SW-1:0] req_set,
    input  logic          lk_hit,
    output logic          accept,
    input  logic          tag_match,
    output phase_e        phase,
    output logic [BW-1:0] cur_bank,
    output logic [RW-1:0] cur_row,
    output logic [SW-1:0] cur_set,
    output logic          done,
    output logic          done_row_hit,
    output logic          done_tag_hit
);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [BW-1:0]    bank;
        logic [RW-1:0]    row;
        logic [SW-1:0]    set;
        logic             rb_hit;
        logic             tag_hit;
        logic             done;
    } fsm_t;

    localparam logic [CNT_W-1:0] L_ACT  = CNT_W'(T_ACT - 1);
    localparam logic [CNT_W-1:0] L_CAS  = CNT_W'(T_CAS - 1);
    localparam logic [CNT_W-1:0] L_BEAT = CNT_W'(BLOCK_BEATS - 1);
    localparam logic [CNT_W-1:0] L_CHK  = CNT_W'(T_CHK - 1);

    fsm_t st_d, st_q;

    assign req_ready = (st_q.ph == PH_IDLE);
    assign accept    = req_ready && req_valid;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.ph == PH_IDLE) begin
            if (req_valid) begin
                st_d.bank    = req_bank;
                st_d.row     = req_row;
                st_d.set     = req_set;
                st_d.rb_hit  = lk_hit;
                st_d.tag_hit = 1'b0;
                if (lk_hit) begin
                    st_d.ph  = PH_CTAG;
                    st_d.cnt = L_CAS;
                end else begin
                    st_d.ph  = PH_ACT;
                    st_d.cnt = L_ACT;
                end
            end
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            unique case (st_q.ph)
                PH_ACT: begin
                    st_d.ph  = PH_CTAG;
                    st_d.cnt = L_CAS;
                end
                PH_CTAG: begin
                    st_d.ph  = PH_BTAG;
                    st_d.cnt = L_BEAT;
                end
                PH_BTAG: begin
                    st_d.ph  = PH_CHK;
                    st_d.cnt = L_CHK;
                end
                PH_CHK: begin
                    if (tag_match) begin
                        st_d.ph      = PH_CDAT;
                        st_d.cnt     = L_CAS;
                        st_d.tag_hit = 1'b1;
                    end else begin
                        st_d.ph      = PH_IDLE;
                        st_d.tag_hit = 1'b0;
                        st_d.done    = 1'b1;
                    end
                end
                PH_CDAT: begin
                    st_d.ph  = PH_BDAT;
                    st_d.cnt = L_BEAT;
                end
                PH_BDAT: begin
                    st_d.ph   = PH_IDLE;
                    st_d.done = 1'b1;
                end
                default: st_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase        = st_q.ph;
    assign cur_bank     = st_q.bank;
    assign cur_row      = st_q.row;
    assign cur_set      = st_q.set;
    assign done         = st_q.done;
    assign done_row_hit = st_q.rb_hit;
    assign done_tag_hit = st_q.tag_hit;

    // R6: a step is left only once its timer has run out
    p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != PH_IDLE && st_q.cnt != '0) |=> (st_q.ph == $past(st_q.ph)));

    // R3: entering the tag read straight from idle needs an open-row match
    p_skip_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.ph) == PH_IDLE && st_q.ph == PH_CTAG) |-> $past(lk_hit));

    // R7: leaving the check for idle is a completion without tag hit
    p_chk_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.ph) == PH_CHK && st_q.ph == PH_IDLE) |-> (done && !done_tag_hit));

    // R9: completion lasts a single cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/dcs_bank_stats.sv
module dcs_bank_stats #(
    parameter int NUM_BANKS = 32,
    parameter int CNT_W     = 16,
    localparam int BW = $clog2(NUM_BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    input  logic [BW-1:0]    bump_bank,
    input  logic             bump_row_hit,
    input  logic [BW-1:0]    rd_bank,
    output logic [CNT_W-1:0] rd_hits,
    output logic [CNT_W-1:0] rd_misses
);

    logic [NUM_BANKS-1:0][CNT_W-1:0] hits_d, hits_q;
    logic [NUM_BANKS-1:0][CNT_W-1:0] miss_d, miss_q;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic sel;
        assign sel = bump && (bump_bank == BW'(g));
        always_comb begin
            hits_d[g] = hits_q[g];
            miss_d[g] = miss_q[g];
            if (sel && bump_row_hit)  hits_d[g] = hits_q[g] + 1'b1;
            if (sel && !bump_row_hit) miss_d[g] = miss_q[g] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hits_q <= '0;
            miss_q <= '0;
        end else begin
            hits_q <= hits_d;
            miss_q <= miss_d;
        end
    end

    assign rd_hits   = hits_q[rd_bank];
    assign rd_misses = miss_q[rd_bank];

    // R10: with no completion the shown counters stay put
    p_idle_counts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bump && $stable(rd_bank)) |=> ($stable(rd_hits) && $stable(rd_misses)));

endmodule

// File: rtl/dcache_bank_seq.sv
module dcache_bank_seq
    import dcs_pkg::*;
#(
    parameter int NUM_BANKS    = 32,
    parameter int NUM_ROWS     = 4096,
    parameter int SETS_PER_ROW = 4,
    parameter int T_ACT        = 18,
    parameter int T_CAS        = 18,
    parameter int BLOCK_BEATS  = 4,
    parameter int T_CHK        = 2,
    parameter int STAT_W       = 16,
    localparam int BW = $clog2(NUM_BANKS),
    localparam int RW = $clog2(NUM_ROWS),
    localparam int SW = $clog2(SETS_PER_ROW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BW-1:0]     req_bank,
    input  logic [RW-1:0]     req_row,
    input  logic [SW-1:0]     req_set,
    input  logic              tag_match,
    output logic [2:0]        phase,
    output logic [BW-1:0]     cur_bank,
    output logic [RW-1:0]     cur_row,
    output logic [SW-1:0]     cur_set,
    output logic              done,
    output logic              done_row_hit,
    output logic              done_tag_hit,
    input  logic [BW-1:0]     stat_bank,
    output logic [STAT_W-1:0] stat_row_hits,
    output logic [STAT_W-1:0] stat_row_misses
);

    logic   lk_hit;
    logic   accept;
    phase_e ph;

    dcs_open_rows #(
        .NUM_BANKS (NUM_BANKS),
        .NUM_ROWS  (NUM_ROWS)
    ) u_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_bank (req_bank),
        .lk_row  (req_row),
        .lk_hit  (lk_hit),
        .wr_en   (accept),
        .wr_bank (req_bank),
        .wr_row  (req_row)
    );

    dcs_access_fsm #(
        .BW          (BW),
        .RW          (RW),
        .SW          (SW),
        .T_ACT       (T_ACT),
        .T_CAS       (T_CAS),
        .BLOCK_BEATS (BLOCK_BEATS),
        .T_CHK       (T_CHK)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_bank     (req_bank),
        .req_row      (req_row),
        .req_set      (req_set),
        .lk_hit       (lk_hit),
        .accept       (accept),
        .tag_match    (tag_match),
        .phase        (ph),
        .cur_bank     (cur_bank),
        .cur_row      (cur_row),
        .cur_set      (cur_set),
        .done         (done),
        .done_row_hit (done_row_hit),
        .done_tag_hit (done_tag_hit)
    );

    dcs_bank_stats #(
        .NUM_BANKS (NUM_BANKS),
        .CNT_W     (STAT_W)
    ) u_stats (
        .clk          (clk),
        .rst_n        (rst_n),
        .bump         (done),
        .bump_bank    (cur_bank),
        .bump_row_hit (done_row_hit),
        .rd_bank      (stat_bank),
        .rd_hits      (stat_row_hits),
        .rd_misses    (stat_row_misses)
    );

    assign phase = ph;

    // R8: no request is taken while an access is in flight
    p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != PH_IDLE) |-> !req_ready);

endmodule

// File: tb/dcache_bank_seq_test.sv
`timescale 1ns/1ps
module dcache_bank_seq_test;

    localparam int T_ACT = 18;
    localparam int HIT_FULL = 46;
    localparam int HIT_TAGMISS = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic [1:0]  req_set = '0;
    logic        tag_match = 1'b0;
    logic [2:0]  phase;
    logic [4:0]  cur_bank;
    logic [11:0] cur_row;
    logic [1:0]  cur_set;
    logic        done, done_row_hit, done_tag_hit;
    logic [4:0]  stat_bank = '0;
    logic [15:0] stat_row_hits, stat_row_misses;

    int checks = 0;
    int failures = 0;
    bit intrude = 1'b0;

    always #10 clk = ~clk;

    dcache_bank_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_set(req_set),
        .tag_match(tag_match), .phase(phase), .cur_bank(cur_bank),
        .cur_row(cur_row), .cur_set(cur_set), .done(done),
        .done_row_hit(done_row_hit), .done_tag_hit(done_tag_hit),
        .stat_bank(stat_bank), .stat_row_hits(stat_row_hits),
        .stat_row_misses(stat_row_misses)
    );

    // {bank[20:16], row[15:4], set[3:2], tag_match[1], expected row hit[0]}
    localparam int NV = 10;
    localparam logic [20:0] VEC [NV] = '{
        {5'd0,  12'd5,    2'd0, 1'b1, 1'b0},  // R2 first touch of bank 0
        {5'd0,  12'd5,    2'd1, 1'b1, 1'b1},  // R3 same row
        {5'd1,  12'd5,    2'd2, 1'b1, 1'b0},  // R5 other bank, own miss
        {5'd0,  12'd5,    2'd3, 1'b0, 1'b1},  // R7 tag mismatch on open row
        {5'd0,  12'd9,    2'd0, 1'b1, 1'b0},  // R4 new row replaces
        {5'd0,  12'd5,    2'd1, 1'b1, 1'b0},  // R4 old row is gone
        {5'd31, 12'd4095, 2'd3, 1'b0, 1'b0},  // R7 tag mismatch on row miss
        {5'd31, 12'd4095, 2'd2, 1'b1, 1'b1},  // R3 last bank, last row
        {5'd1,  12'd5,    2'd0, 1'b1, 1'b1},  // R5 bank 1 kept its row
        {5'd0,  12'd5,    2'd3, 1'b1, 1'b1}   // R3 reopened row hits
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_access(input logic [4:0] b, input logic [11:0] r,
                              input logic [1:0] s, input logic tm, input logic exp_rb);
        int lat = 0, act_c = 0, data_c = 0, ready_busy = 0, guard = 0;
        int exp_lat;
        exp_lat = (exp_rb ? 0 : T_ACT) + (tm ? HIT_FULL : HIT_TAGMISS);
        @(negedge clk);
        while (!req_ready && guard < 200) begin @(negedge clk); guard++; end
        req_valid = 1'b1; req_bank = b; req_row = r; req_set = s; tag_match = tm;
        @(posedge clk);
        forever begin
            @(negedge clk);
            if (lat == 0) begin
                req_valid = 1'b0;
                check(cur_bank == b && cur_row == r && cur_set == s,
                      "R6 address held", int'(cur_row), int'(r));
                if (intrude) begin
                    req_valid = 1'b1; req_bank = 5'd2; req_row = 12'd7;
                end
            end
            if (done || lat > 200) break;
            if (req_ready) ready_busy++;
            if (phase == 3'd1) act_c++;
            if (phase == 3'd5 || phase == 3'd6) data_c++;
            lat++;
        end
        req_valid = 1'b0;
        check(done == 1'b1 && lat == exp_lat, exp_rb ? "R3 latency" : "R2 latency", lat, exp_lat);
        check(done_row_hit == exp_rb, "R4 row-buffer outcome", int'(done_row_hit), int'(exp_rb));
        check(done_tag_hit == tm, "R9 tag outcome", int'(done_tag_hit), int'(tm));
        check(act_c == (exp_rb ? 0 : 18), "R6 activation cycles", act_c, exp_rb ? 0 : 18);
        check(data_c == (tm ? 22 : 0), "R7 data phase cycles", data_c, tm ? 22 : 0);
        check(ready_busy == 0, "R8 ready low while busy", ready_busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R9 done single cycle", int'(done), 0);
    endtask

    task automatic check_stats(input logic [4:0] b, input int eh, input int em);
        stat_bank = b;
        #1;
        check(int'(stat_row_hits) == eh, "R10 hit counter", int'(stat_row_hits), eh);
        check(int'(stat_row_misses) == em, "R10 miss counter", int'(stat_row_misses), em);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && done == 1'b0 && phase == 3'd0,
              "R1 reset outputs", int'(phase), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && phase == 3'd0, "R1 idle after reset", int'(phase), 0);
        check_stats(5'd0, 0, 0);

        for (int i = 0; i < NV; i++) begin
            run_access(VEC[i][20:16], VEC[i][15:4], VEC[i][3:2], VEC[i][1], VEC[i][0]);
        end

        // R8: a request from bank 2 stays valid through a whole access
        intrude = 1'b1;
        run_access(5'd1, 12'd5, 2'd1, 1'b1, 1'b1);
        intrude = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        check(phase == 3'd0, "R8 stays idle after busy request dropped", int'(phase), 0);
        check_stats(5'd2, 0, 0);

        check_stats(5'd0, 3, 3);
        check_stats(5'd1, 2, 1);
        check_stats(5'd31, 1, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule